// File: doc/BRIEF.md
# Direct-Sequence Spreading Transmitter

This block converts a stream of 8-bit audio samples into a baseband direct-sequence spread chip stream. Each sample is broken into its bits, most significant bit first. Each bit becomes one symbol, and a symbol is one complete period of a fixed spreading code. A one bit sends the code unchanged. A zero bit sends every chip of the code inverted. Chips leave the block as signed values of +1 or -1, one chip for each pulse of the chip-rate enable.

A pulse on `start` begins transmission. Before any data, the block sends a synchronization run of `sync_syms` symbols. Every symbol in this run carries a forced one bit, so the receiver sees the code repeat with constant polarity and can lock its timing before data begins. After the run, the block spreads data until reset. The code pattern and its length (8 or 16 chips) are parameters.

Samples arrive on a valid/ready interface. The block raises `smp_ready` for exactly one cycle, and only at a symbol boundary: the cycle in which the first chip of a new sample would be produced. A source may hold `smp_valid` with stable data for as long as it likes. The data is taken only in a cycle where both signals are high. If no sample is waiting at that boundary, the block sends one symbol carrying a zero bit, raises `underflow`, and offers `smp_ready` again at the next symbol boundary.

Top module: `ds_spread_tx`

## Requirements
- R1: After reset the block is idle. In idle, `chip_out` is 0, `smp_ready`, `underflow` and `sync_phase` are 0, and pulses on `chip_en` have no effect.
- R2: A `start` pulse while idle latches `sync_syms` and enters the synchronization run. The run lasts that many symbols, with `sync_phase` high throughout and `smp_ready` held low. Each symbol in the run sends the code uninverted.
- R3: A `start` with `sync_syms` equal to 0 skips the synchronization run. The first symbol after it is already a data symbol.
- R4: A `start` pulse while the block is not idle is ignored. Spreading continues unchanged, and `sync_phase` stays low.
- R5: Each `chip_en` pulse in an active mode produces one chip. The chip is registered into `chip_out` and appears in the cycle after the pulse. Without a pulse, `chip_out` holds its value.
- R6: Chip k of a symbol (k = 0 first) uses code bit `CODE[CODE_LEN-1-k]`. A symbol bit of 1 sends +1 (2'b01) when that code bit is 1 and -1 (2'b11) when it is 0. A symbol bit of 0 inverts every chip. Sample bits are sent from bit 7 down to bit 0.
- R7: `smp_ready` is high only in a cycle with `chip_en` high, at chip 0 of a data symbol, once the previous sample's last symbol has finished. A sample held valid earlier is not taken before that point. Back-to-back samples leave no gap between them.
- R8: If `smp_valid` is low at a sample boundary, the block sends one symbol with bit 0 and raises `underflow` for one cycle, together with that symbol's first chip. The next symbol boundary offers `smp_ready` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin transmission (honoured only when idle) |
| sync_syms | input | SYNC_W | Length of the synchronization run in symbols, latched on start |
| smp_data | input | SAMPLE_W | Audio sample |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample taken this cycle when valid is high |
| chip_en | input | 1 | Chip-rate enable, one chip per pulse |
| chip_out | output | 2 | Signed chip: +1, -1, or 0 when idle |
| underflow | output | 1 | One-cycle pulse: a zero bit was sent for lack of a sample |
| sync_phase | output | 1 | High during the synchronization run |

## Verification
A wrong chip index or symbol bit shows up at the very next chip on `chip_out`, as a chip of the wrong sign. A wrong bit counter in the serializer shows up as `smp_ready` arriving one symbol early or late, which the bench sees at the first chip of the affected symbol. It also shifts every later bit of the stream by one position. A wrong synchronization count shows up when `sync_phase` falls at the wrong time, and as `smp_ready` appearing inside the run or a forced-one symbol appearing where data was expected. All of these become visible within one symbol period, which is `CODE_LEN` chip pulses.

// File: rtl/ds_spread_pkg.sv
package ds_spread_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_SYNC = 2'd1,
    M_DATA = 2'd2
  } tx_mode_e;

  // Code bit equal to symbol bit gives +1, otherwise -1.
  function automatic logic signed [1:0] chip_level(input logic code_bit, input logic sym_bit);
    return (code_bit ~^ sym_bit) ? 2'sb01 : 2'sb11;
  endfunction
endpackage

// File: rtl/ds_code_src.sv
module ds_code_src #(
  parameter int          CODE_LEN = 16,
  parameter logic [15:0] CODE     = 16'h1E6B,
  localparam int         IDX_W    = $clog2(CODE_LEN)
) (
  input  logic [IDX_W-1:0] idx,
  output logic             code_bit
);
  // Chip 0 takes the most significant code bit; for a power-of-two
  // length the reversed index is the bitwise complement.
  generate
    if (CODE_LEN == 8) begin : g_short
      localparam logic [7:0] SEQ = CODE[7:0];
      assign code_bit = SEQ[~idx];
    end else begin : g_long
      localparam logic [15:0] SEQ = CODE[15:0];
      assign code_bit = SEQ[~idx];
    end
  endgenerate
endmodule

// File: rtl/ds_seq_ctrl.sv
module ds_seq_ctrl
  import ds_spread_pkg::*;
#(
  parameter int CODE_LEN = 16,
  parameter int SYNC_W   = 8,
  localparam int IDX_W   = $clog2(CODE_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SYNC_W-1:0] sync_syms,
  input  logic              chip_en,
  output tx_mode_e          mode,
  output logic [IDX_W-1:0]  chip_idx,
  output logic              sym_first,
  output logic              sym_last
);
  logic [SYNC_W-1:0] sync_left;

  assign sym_first = (chip_idx == '0);
  assign sym_last  = (chip_idx == IDX_W'(CODE_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= M_IDLE;
      chip_idx  <= '0;
      sync_left <= '0;
    end else if (mode == M_IDLE) begin
      if (start) begin
        sync_left <= sync_syms;
        chip_idx  <= '0;
        mode      <= (sync_syms == '0) ? M_DATA : M_SYNC;
      end
    end else if (chip_en) begin
      chip_idx <= chip_idx + IDX_W'(1);
      if (sym_last && mode == M_SYNC) begin
        sync_left <= sync_left - SYNC_W'(1);
        if (sync_left == SYNC_W'(1)) mode <= M_DATA;
      end
    end
  end
endmodule

// File: rtl/ds_serializer.sv
module ds_serializer #(
  parameter int SAMPLE_W = 8,
  localparam int BIT_W   = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                sym_first,
  input  logic                sym_last,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                smp_valid,
  output logic                smp_ready,
  output logic                data_bit,
  output logic                uf_hit
);
  logic [SAMPLE_W-1:0] shreg;
  logic [BIT_W-1:0]    bits_left;
  logic                cur_bit;
  logic                need_load;
  logic                new_bit;

  assign new_bit   = need_load ? (smp_valid & smp_data[SAMPLE_W-1]) : shreg[SAMPLE_W-1];
  assign data_bit  = sym_first ? new_bit : cur_bit;
  assign smp_ready = step & sym_first & need_load;
  assign uf_hit    = smp_ready & ~smp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      bits_left <= '0;
      cur_bit   <= 1'b0;
      need_load <= 1'b1;
    end else if (step) begin
      if (sym_first) begin
        cur_bit <= new_bit;
        if (need_load) begin
          if (smp_valid) begin
            shreg     <= smp_data << 1;
            bits_left <= BIT_W'(SAMPLE_W - 1);
            need_load <= 1'b0;
          end
        end else begin
          shreg     <= shreg << 1;
          bits_left <= bits_left - BIT_W'(1);
        end
      end
      if (sym_last && !need_load && bits_left == '0) need_load <= 1'b1;
    end
  end
endmodule

// File: rtl/ds_spread_tx.sv
module ds_spread_tx
  import ds_spread_pkg::*;
#(
  parameter int          SAMPLE_W = 8,
  parameter int          CODE_LEN = 16,
  parameter logic [15:0] CODE     = 16'h1E6B,
  parameter int          SYNC_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SYNC_W-1:0]   sync_syms,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic                chip_en,
  output logic signed [1:0]   chip_out,
  output logic                underflow,
  output logic                sync_phase
);
  localparam int IDX_W = $clog2(CODE_LEN);

  tx_mode_e         mode;
  logic [IDX_W-1:0] chip_idx;
  logic             sym_first, sym_last;
  logic             code_bit, data_bit, uf_hit, sym_bit, data_step;

  ds_seq_ctrl #(.CODE_LEN(CODE_LEN), .SYNC_W(SYNC_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sync_syms(sync_syms),
    .chip_en(chip_en), .mode(mode), .chip_idx(chip_idx),
    .sym_first(sym_first), .sym_last(sym_last)
  );

  ds_code_src #(.CODE_LEN(CODE_LEN), .CODE(CODE)) code_i (
    .idx(chip_idx), .code_bit(code_bit)
  );

  assign data_step = chip_en && (mode == M_DATA);

  ds_serializer #(.SAMPLE_W(SAMPLE_W)) ser_i (
    .clk(clk), .rst_n(rst_n), .step(data_step), .sym_first(sym_first),
    .sym_last(sym_last), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .data_bit(data_bit), .uf_hit(uf_hit)
  );

  assign sym_bit    = (mode == M_SYNC) ? 1'b1 : data_bit;
  assign sync_phase = (mode == M_SYNC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chip_out  <= 2'sb00;
      underflow <= 1'b0;
    end else begin
      underflow <= uf_hit;
      if (chip_en && mode != M_IDLE) chip_out <= chip_level(code_bit, sym_bit);
    end
  end
endmodule

// File: rtl/ds_spread_tx_chk.sv
module ds_spread_tx_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic signed [1:0] chip_out,
  input logic              underflow,
  input logic              sync_phase
);
  AST_READY_NEEDS_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> chip_en); // R7
  AST_CHIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> $stable(chip_out)); // R5
  AST_UF_FROM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(smp_ready && !smp_valid)); // R8
  AST_UF_WITH_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (chip_out != 2'sb00)); // R8
  AST_NO_READY_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sync_phase |-> !smp_ready); // R2
endmodule

bind ds_spread_tx ds_spread_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .chip_out(chip_out), .underflow(underflow),
  .sync_phase(sync_phase)
);

// File: tb/ds_spread_tx_tb_top.sv
module ds_spread_tx_tb_top;
  localparam logic [15:0] TB_CODE = 16'h1E6B;
  localparam int          TB_LEN  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [7:0]        sync_syms = '0;
  logic [7:0]        smp_data = '0;
  logic              smp_valid = 1'b0;
  logic              smp_ready;
  logic              chip_en = 1'b0;
  logic signed [1:0] chip_out;
  logic              underflow;
  logic              sync_phase;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ds_spread_tx #(.SAMPLE_W(8), .CODE_LEN(TB_LEN), .CODE(TB_CODE), .SYNC_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sync_syms(sync_syms),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .chip_en(chip_en), .chip_out(chip_out), .underflow(underflow),
    .sync_phase(sync_phase)
  );

  function automatic logic signed [1:0] exp_chip(input int k, input logic b);
    return (TB_CODE[TB_LEN-1-k] == b) ? 2'sb01 : 2'sb11;
  endfunction

  task automatic check(input logic ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chip_step(input logic gap, output logic signed [1:0] c, output logic r,
                           output logic u, output logic held);
    @(negedge clk);
    chip_en = 1'b1;
    #1;
    r = smp_ready;
    @(negedge clk);
    chip_en = 1'b0;
    c = chip_out;
    u = underflow;
    held = 1'b1;
    if (gap) begin
      @(negedge clk);
      @(negedge clk);
      held = (chip_out === c);
    end
  endtask

  task automatic sym(input logic b, input logic exp_rdy, input logic exp_uf, input string req);
    int bad = 0;
    logic signed [1:0] c;
    logic r, u, h, r0;
    logic extra_r = 1'b0;
    r0 = 1'b0;
    for (int k = 0; k < TB_LEN; k++) begin
      chip_step((k % 5) == 2, c, r, u, h);
      if (k == 0) begin
        r0 = r;
        if (r && smp_valid) smp_valid = 1'b0;
      end else if (r) extra_r = 1'b1;
      if (c !== exp_chip(k, b)) bad++;
      if (u !== ((k == 0) && exp_uf)) bad++;
      if (!h) bad++;
    end
    check(bad == 0, req, "symbol chip/underflow/hold mismatches", bad, 0);
    check(r0 === exp_rdy && !extra_r, req, "ready at symbol boundary", {extra_r, r0}, {1'b0, exp_rdy});
  endtask

  task automatic send_sample(input logic [7:0] v, input string req, input logic early, input logic [7:0] nxt);
    smp_data = v;
    smp_valid = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sym(v[i], i == 7, 1'b0, req);
      if (i == 7 && early) begin
        smp_data = nxt;
        smp_valid = 1'b1;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smp_valid = 1'b0;
    start = 1'b0;
    chip_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_start(input logic [7:0] n);
    @(negedge clk);
    start = 1'b1;
    sync_syms = n;
    @(negedge clk);
    start = 1'b0;
    sync_syms = 8'd77;
  endtask

  task automatic t_reset();
    logic signed [1:0] c;
    logic r, u, h;
    do_reset();
    check(chip_out === 2'sb00 && !smp_ready && !underflow && !sync_phase, "R1", "idle outputs",
          {chip_out, smp_ready, underflow, sync_phase}, 0);
    smp_valid = 1'b1;
    smp_data = 8'hFF;
    for (int k = 0; k < 4; k++) begin
      chip_step(1'b0, c, r, u, h);
      check(c === 2'sb00 && !r && !u, "R1", "chip_en ignored in idle", {c, r, u}, 0);
    end
    smp_valid = 1'b0;
  endtask

  task automatic t_sync();
    do_start(8'd2);
    check(sync_phase === 1'b1, "R2", "sync_phase after start", sync_phase, 1);
    smp_data = 8'h00;
    smp_valid = 1'b1;
    sym(1'b1, 1'b0, 1'b0, "R2");
    check(sync_phase === 1'b1, "R2", "sync_phase mid run", sync_phase, 1);
    sym(1'b1, 1'b0, 1'b0, "R2");
    check(sync_phase === 1'b0, "R2", "sync_phase after run", sync_phase, 0);
  endtask

  task automatic t_data();
    send_sample(8'hA5, "R6", 1'b1, 8'h3C);
    send_sample(8'h3C, "R7", 1'b0, 8'h00);
  endtask

  task automatic t_underflow();
    smp_valid = 1'b0;
    sym(1'b0, 1'b1, 1'b1, "R8");
    sym(1'b0, 1'b1, 1'b1, "R8");
    send_sample(8'hC1, "R8", 1'b0, 8'h00);
  endtask

  task automatic t_start_busy();
    do_start(8'd3);
    check(sync_phase === 1'b0, "R4", "start while busy", sync_phase, 0);
    send_sample(8'h5E, "R4", 1'b0, 8'h00);
  endtask

  task automatic t_hold();
    logic signed [1:0] c0;
    c0 = chip_out;
    repeat (6) @(negedge clk);
    check(chip_out === c0, "R5", "chip_out held without chip_en", chip_out, c0);
  endtask

  task automatic t_zero_sync();
    do_reset();
    do_start(8'd0);
    check(sync_phase === 1'b0, "R3", "no sync run", sync_phase, 0);
    send_sample(8'h81, "R3", 1'b0, 8'h00);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_sync();
    t_data();
    t_underflow();
    t_start_busy();
    t_hold();
    t_zero_sync();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule